// File: doc/BRIEF.md
# Latency-Hiding Thread Issue Scheduler

This block picks, on every clock, at most one hardware thread slot that may issue an instruction. Each slot carries a launched bit and a ready/blocked scheduling state. Switching between threads on each issue, rather than waiting on deep caches, keeps the pipeline busy while some threads wait on memory.

A slot becomes launched and ready through the launch input. When the instruction shown on the issue output makes a memory reference, the surrounding pipeline raises `issue_mem` in that same cycle, and the slot becomes blocked. A completion carrying the slot number returns the slot to ready. The choice among eligible slots rotates round-robin, starting from the slot after the one issued last. When slots are launched but none can issue, a stall indication is raised instead. A completion that names a slot which is not blocked is dropped and sets a sticky error flag.

Top module: `thread_issue_sched`

## Requirements
- R1: After synchronous reset, `issue_valid`, `stall` and `cpl_err` are 0 and no slot is launched.
- R2: A launch sampled at a rising edge marks slot `launch_tid` launched and ready. That slot can first appear on the issue output at the next rising edge.
- R3: Only slots that are launched and ready are ever issued. A slot that was never launched never shows on `issue_tid` while `issue_valid` is 1.
- R4: Arbitration is round-robin. The next issue goes to the first eligible slot found by searching upward, with wrap-around, from the slot after the last one issued. After reset the search starts at slot 0.
- R5: If `issue_mem` is 1 in a cycle where `issue_valid` is 1, slot `issue_tid` is blocked at that edge and is not the one issued at that edge.
- R6: A completion for a blocked slot makes it ready at the edge where the completion is sampled. The slot is not issued at that edge and may be issued from the following edge onward.
- R7: `stall` is 1 in exactly the cycles where at least one slot was launched but nothing was eligible, and `issue_valid` is then 0. With no slot launched, `stall` stays 0.
- R8: A completion naming a slot that is not blocked leaves every slot's state unchanged and sets `cpl_err` from the next edge.
- R9: If a completion and a block hit the same slot in the same cycle, the completion is applied first and the slot ends blocked.
- R10: `cpl_err` stays 1 until reset, whatever inputs follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch a slot this cycle |
| launch_tid | input | TID_W (3) | Slot being launched |
| issue_mem | input | 1 | The instruction on the issue output makes a memory reference |
| cpl_valid | input | 1 | Memory completion this cycle |
| cpl_tid | input | TID_W (3) | Slot the completion belongs to |
| issue_valid | output | 1 | A slot is issued this cycle (registered) |
| issue_tid | output | TID_W (3) | Issued slot, meaningful when `issue_valid` is 1 |
| stall | output | 1 | Launched slots exist but none could issue (registered) |
| cpl_err | output | 1 | Sticky flag for a completion to a slot that was not blocked |

## Verification
The state of every slot changes at the edge that samples a launch, a block or a completion. The issue and stall outputs are registered, so any such change reaches them one edge later. The sticky error flag is visible right after the edge that sampled the offending completion. The bench drives inputs just after each falling edge and reads outputs at the next falling edge. Each expected issue number therefore comes from the state settled at the previous edge, for example the slot issued at the edge that samples its own completion must still be the old choice. Round-robin order is checked as exact slot sequences across launch, block and wake-up transitions.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int DEF_THREADS = 8;

  function automatic int wrap_idx(input int base, input int step, input int n);
    int v;
    v = base + step;
    if (v >= n) v = v - n;
    return v;
  endfunction
endpackage

// File: rtl/thread_state_table.sv
module thread_state_table #(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   launch_en,
  input  logic [TID_W-1:0]       launch_id,
  input  logic                   blk_en,
  input  logic [TID_W-1:0]       blk_id,
  input  logic                   cpl_en,
  input  logic [TID_W-1:0]       cpl_id,
  output logic [NUM_THREADS-1:0] valid_o,
  output logic [NUM_THREADS-1:0] ready_o,
  output logic                   err_o
);
  logic [NUM_THREADS-1:0] valid_q, ready_q, ready_nxt;
  logic                   err_q, stray_cpl;

  // a completion is legal only for a launched, blocked slot
  assign stray_cpl = cpl_en && !(valid_q[cpl_id] && !ready_q[cpl_id]);

  for (genvar s = 0; s < NUM_THREADS; s++) begin : g_slot
    logic hit_cpl, hit_blk, hit_launch;
    assign hit_cpl    = cpl_en && (cpl_id == TID_W'(s)) && valid_q[s] && !ready_q[s];
    assign hit_blk    = blk_en && (blk_id == TID_W'(s));
    assign hit_launch = launch_en && (launch_id == TID_W'(s));

    // completion first, then block, then launch
    always_comb begin
      ready_nxt[s] = ready_q[s];
      if (hit_cpl)    ready_nxt[s] = 1'b1;
      if (hit_blk)    ready_nxt[s] = 1'b0;
      if (hit_launch) ready_nxt[s] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[s] <= 1'b0;
        ready_q[s] <= 1'b0;
      end else begin
        if (hit_launch) valid_q[s] <= 1'b1;
        ready_q[s] <= ready_nxt[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (stray_cpl) err_q <= 1'b1;
  end

  assign valid_o = valid_q;
  assign ready_o = ready_q;
  assign err_o   = err_q;

  a_r8_stray_sets_err: assert property (@(posedge clk) disable iff (rst)
    (cpl_en && !(valid_o[cpl_id] && !ready_o[cpl_id])) |=> err_o);

  a_r9_cpl_then_block: assert property (@(posedge clk) disable iff (rst)
    (cpl_en && blk_en && (cpl_id == blk_id) && !(launch_en && launch_id == blk_id))
      |=> !ready_o[$past(blk_id)]);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] elig,
  input  logic [TID_W-1:0]       last,
  output logic                   gnt_valid,
  output logic [TID_W-1:0]       gnt_idx
);
  import sched_pkg::*;

  always_comb begin
    int idx;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      idx = wrap_idx(int'(last), k, NUM_THREADS);
      if (!gnt_valid && elig[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = TID_W'(idx);
      end
    end
  end

  always_comb begin
    a_r4_grant_is_eligible: assert (!gnt_valid || elig[gnt_idx]);
  end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
  parameter int NUM_THREADS = sched_pkg::DEF_THREADS,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_valid,
  input  logic [TID_W-1:0] launch_tid,
  input  logic             issue_mem,
  input  logic             cpl_valid,
  input  logic [TID_W-1:0] cpl_tid,
  output logic             issue_valid,
  output logic [TID_W-1:0] issue_tid,
  output logic             stall,
  output logic             cpl_err
);
  logic [NUM_THREADS-1:0] slot_valid, slot_ready, blk_mask, elig;
  logic                   blk_now, gnt_valid;
  logic [TID_W-1:0]       gnt_idx;
  logic                   issue_valid_q, stall_q;
  logic [TID_W-1:0]       issue_tid_q;

  assign blk_now = issue_valid_q && issue_mem;

  thread_state_table #(.NUM_THREADS(NUM_THREADS)) u_table (
    .clk       (clk),
    .rst       (rst),
    .launch_en (launch_valid),
    .launch_id (launch_tid),
    .blk_en    (blk_now),
    .blk_id    (issue_tid_q),
    .cpl_en    (cpl_valid),
    .cpl_id    (cpl_tid),
    .valid_o   (slot_valid),
    .ready_o   (slot_ready),
    .err_o     (cpl_err)
  );

  // a slot blocking at this edge must not be chosen again
  always_comb begin
    blk_mask = '0;
    if (blk_now) blk_mask[issue_tid_q] = 1'b1;
  end
  assign elig = slot_valid & slot_ready & ~blk_mask;

  rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .elig      (elig),
    .last      (issue_tid_q),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid_q <= 1'b0;
      issue_tid_q   <= TID_W'(NUM_THREADS - 1);
      stall_q       <= 1'b0;
    end else begin
      issue_valid_q <= gnt_valid;
      if (gnt_valid) issue_tid_q <= gnt_idx;
      stall_q <= (|slot_valid) && !gnt_valid;
    end
  end

  assign issue_valid = issue_valid_q;
  assign issue_tid   = issue_tid_q;
  assign stall       = stall_q;

  a_r7_stall_excl: assert property (@(posedge clk) disable iff (rst)
    stall |-> !issue_valid);

  a_r3_issue_launched: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> slot_valid[issue_tid]);

  a_r5_no_reissue: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_mem) |=> !(issue_valid && (issue_tid == $past(issue_tid))));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cpl_err |=> cpl_err);
endmodule

// File: tb/sim_thread_issue_sched.sv
module sim_thread_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          launch_valid = 1'b0;
  logic [TW-1:0] launch_tid = '0;
  logic          issue_mem = 1'b0;
  logic          cpl_valid = 1'b0;
  logic [TW-1:0] cpl_tid = '0;
  logic          issue_valid, stall, cpl_err;
  logic [TW-1:0] issue_tid;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  thread_issue_sched u0 (
    .clk(clk), .rst(rst),
    .launch_valid(launch_valid), .launch_tid(launch_tid),
    .issue_mem(issue_mem), .cpl_valid(cpl_valid), .cpl_tid(cpl_tid),
    .issue_valid(issue_valid), .issue_tid(issue_tid),
    .stall(stall), .cpl_err(cpl_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_issue(input string req, input int tid);
    check(issue_valid === 1'b1 && int'(issue_tid) == tid, req,
          issue_valid ? int'(issue_tid) : -1, tid);
  endtask

  task automatic do_reset();
    rst = 1'b1; launch_valid = 0; issue_mem = 0; cpl_valid = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(issue_valid === 1'b0, "R1 issue_valid", issue_valid, 0);
    check(stall === 1'b0, "R1 stall", stall, 0);
    check(cpl_err === 1'b0, "R1 cpl_err", cpl_err, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      check(stall === 1'b0 && issue_valid === 1'b0, "R7 idle no stall", stall, 0);
    end
  endtask

  task automatic t_launch_rr();
    do_reset();
    launch_valid = 1; launch_tid = 0;
    step();
    check(issue_valid === 1'b0, "R2 not yet issued", issue_valid, 0);
    launch_tid = 1;
    step(); expect_issue("R2 first issue", 0);
    launch_tid = 2;
    step(); expect_issue("R4 order", 1);
    launch_tid = 3;
    step(); expect_issue("R4 order", 2);
    launch_valid = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      expect_issue("R4 rotation", (i + 3) % 4);
      check(issue_tid < 4, "R3 unlaunched slot", issue_tid, 0);
    end
  endtask

  task automatic t_block_wake();
    int guard = 0;
    while (!(issue_valid && issue_tid == 2) && guard < 10) begin
      step(); guard++;
    end
    issue_mem = 1;
    step(); issue_mem = 0;
    expect_issue("R5 skip blocked", 3);
    step(); expect_issue("R5 skip blocked", 0);
    step(); expect_issue("R5 skip blocked", 1);
    step(); expect_issue("R5 skip blocked", 3);
    step(); expect_issue("R5 skip blocked", 0);
    step(); expect_issue("R5 skip blocked", 1);
    cpl_valid = 1; cpl_tid = 2;
    step(); cpl_valid = 0;
    expect_issue("R6 not at completion edge", 3);
    step(); expect_issue("R6 after wake", 0);
    step(); expect_issue("R6 after wake", 1);
    step(); expect_issue("R6 woken slot issues", 2);
    check(cpl_err === 1'b0, "R8 legal completion", cpl_err, 0);
  endtask

  task automatic t_stall_collide();
    do_reset();
    launch_valid = 1; launch_tid = 0;
    step(); launch_valid = 0;
    step(); expect_issue("R2 single slot", 0);
    issue_mem = 1; cpl_valid = 1; cpl_tid = 0;
    step(); issue_mem = 0; cpl_valid = 0;
    check(stall === 1'b1 && issue_valid === 1'b0, "R7 stall all blocked", stall, 1);
    check(cpl_err === 1'b1, "R8 err on ready slot", cpl_err, 1);
    step();
    check(stall === 1'b1, "R9 slot ends blocked", stall, 1);
    step();
    check(stall === 1'b1 && issue_valid === 1'b0, "R9 still blocked", issue_valid, 0);
    cpl_valid = 1; cpl_tid = 0;
    step(); cpl_valid = 0;
    check(stall === 1'b1 && issue_valid === 1'b0, "R6 no issue at completion edge", issue_valid, 0);
    check(cpl_err === 1'b1, "R10 err sticky", cpl_err, 1);
    step();
    expect_issue("R6 issue after wake", 0);
    check(stall === 1'b0, "R7 stall clears", stall, 0);
    step(); expect_issue("R4 lone slot repeats", 0);
    check(cpl_err === 1'b1, "R10 err sticky", cpl_err, 1);
  endtask

  task automatic t_stray();
    int prev;
    do_reset();
    check(cpl_err === 1'b0, "R1 err cleared by reset", cpl_err, 0);
    launch_valid = 1; launch_tid = 0;
    step(); launch_tid = 1;
    step(); launch_valid = 0;
    step(); step();
    cpl_valid = 1; cpl_tid = 1;
    step(); cpl_valid = 0;
    check(cpl_err === 1'b1, "R8 stray completion flagged", cpl_err, 1);
    prev = int'(issue_tid);
    for (int i = 0; i < 4; i++) begin
      step();
      expect_issue("R8 state unchanged", prev ^ 1);
      prev = int'(issue_tid);
    end
    cpl_valid = 1; cpl_tid = 6;
    step(); cpl_valid = 0;
    step();
    check(issue_tid < 2 && issue_valid, "R8 unlaunched completion ignored", issue_tid, 0);
    check(cpl_err === 1'b1, "R10 err sticky", cpl_err, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    step();
    t_reset();
    t_launch_rr();
    t_block_wake();
    t_stall_collide();
    t_stray();
    finish_run();
  end

  initial begin
    wait (cycles > 5000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
    finish_run();
  end
endmodule